// File: doc/BRIEF.md
# Blocked LU Index Sequencer

This block issues the index triples that steer a column-blocked LU factorisation, one triple per clock while the consumer accepts them. A triple holds a pivot row `i`, the first column `k` of a block of `K` columns, and an update row `j`. The matrix order `N` is given with the start pulse at run time. The parallel width `K` is a build-time parameter.

For each pivot row, the column-block index starts at the `K`-aligned block that contains the pivot column, so blocks to the left that are already finished are skipped. The sequence is nested: `j` varies fastest, then `k`, then `i`. Counters in a first register stage feed a second output register. An index update therefore reaches the outputs two clocks after it is made. A ready input from the consumer stalls the whole pipeline. A one-clock done pulse marks the end of a run.

Top module: `lu_idx_gen`

## Requirements
- R1: While reset is asserted and after it is released, `idx_valid` and `done` are 0 until a run is started.
- R2: A `start` sampled high while idle latches `n_order`. `idx_valid` first goes high after the second rising edge that follows, carrying the triple i=1, k=0, j=1.
- R3: Triples appear in nested order: `j` innermost, `k` in the middle, `i` outermost. `i` takes the values 1 to N. For each (i, k), `j` takes the values i to N in steps of 1.
- R4: For each `i`, `k` starts at floor((i-1)/K)*K and grows by K while k <= N+1-K. Every issued `k` is a multiple of K.
- R5: While `idx_valid` is 1 and `ready` is 0, the presented triple stays unchanged and the sequence does not advance.
- R6: A triple is accepted when `idx_valid` and `ready` are both 1. Once the first triple has appeared, `idx_valid` stays high, so with `ready` held high a new triple is presented after every clock until the run ends.
- R7: `done` is high for exactly one clock, in the cycle after the final triple is accepted. `idx_valid` is 0 in that cycle.
- R8: A `start` pulse while a run is in progress is ignored. This covers every cycle from acceptance of a start up to and including the edge where the final triple is accepted.
- R9: A change of `n_order` during a run has no effect. The order latched at start governs the whole run.
- R10: `n_order` must be a power of two with K <= N <= NMAX. `K` and `NMAX` must be powers of two with K <= NMAX, and elaboration rejects other values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| n_order | input | $clog2(NMAX)+1 | Matrix order N, sampled with start |
| ready | input | 1 | Consumer accepts the presented triple |
| idx_valid | output | 1 | A triple is presented |
| idx_i | output | $clog2(NMAX)+1 | Pivot row index |
| idx_k | output | $clog2(NMAX)+1 | First column of the current block |
| idx_j | output | $clog2(NMAX)+1 | Row being updated |
| done | output | 1 | One-clock pulse after the final triple is accepted |

## Verification
The bench builds the block with K=4 and NMAX=32. With this small width it can run several complete sequences, using N equal to K and N equal to NMAX. Between those runs it covers the skipping of finished blocks at every multiple-of-four boundary of `i`. N=4 brings the single-block case into reach, where `k` never leaves 0. N=8, N=16 and N=32 cover pivots whose starting block moves across one, three and seven boundaries. Ready patterns are continuous, one-in-three low and pseudo-random. One run injects extra starts and order changes mid-sequence. All runs are compared clock by clock against a queue-based model.

// File: rtl/lu_idx_pkg.sv
package lu_idx_pkg;

   typedef enum logic [1:0] {
      STEP_J   = 2'd0,
      STEP_K   = 2'd1,
      STEP_I   = 2'd2,
      STEP_END = 2'd3
   } step_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lu_idx_step.sv
module lu_idx_step
   import lu_idx_pkg::*;
#(
   parameter int K    = 8,
   parameter int NMAX = 128,
   localparam int IW  = $clog2(NMAX) + 1,
   localparam int EW  = IW + 2
) (
   input  logic [IW-1:0] n,
   input  logic [IW-1:0] cur_i,
   input  logic [IW-1:0] cur_k,
   input  logic [IW-1:0] cur_j,
   output logic [IW-1:0] nxt_i,
   output logic [IW-1:0] nxt_k,
   output logic [IW-1:0] nxt_j,
   output logic          is_last
);

   logic          j_end;
   logic          k_end;
   logic          i_end;
   logic [IW-1:0] k_base;
   logic [EW-1:0] k_probe;
   step_e         kind;

   assign j_end   = (cur_j == n);
   assign i_end   = (cur_i == n);
   assign k_probe = EW'(cur_k) + EW'(2 * K);
   assign k_end   = (k_probe > (EW'(n) + EW'(1)));

   generate
      if (K == 1) begin : g_unit
         assign k_base = cur_i;
      end else begin : g_masked
         localparam logic [IW-1:0] KMASK = ~IW'(K - 1);
         assign k_base = cur_i & KMASK;
      end
   endgenerate

   always_comb begin
      if (!j_end)      kind = STEP_J;
      else if (!k_end) kind = STEP_K;
      else if (!i_end) kind = STEP_I;
      else             kind = STEP_END;
   end

   always_comb begin
      nxt_i = cur_i;
      nxt_k = cur_k;
      nxt_j = cur_j;
      unique case (kind)
         STEP_J: nxt_j = cur_j + IW'(1);
         STEP_K: begin
            nxt_k = cur_k + IW'(K);
            nxt_j = cur_i;
         end
         STEP_I: begin
            nxt_i = cur_i + IW'(1);
            nxt_k = k_base;
            nxt_j = cur_i + IW'(1);
         end
         default: ;
      endcase
   end

   assign is_last = (kind == STEP_END);

endmodule

// File: rtl/lu_idx_front.sv
module lu_idx_front #(
   parameter int K    = 8,
   parameter int NMAX = 128,
   localparam int IW  = $clog2(NMAX) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          advance,
   input  logic [IW-1:0] n_in,
   output logic [IW-1:0] n_q,
   output logic          s1_valid,
   output logic [IW-1:0] s1_i,
   output logic [IW-1:0] s1_k,
   output logic [IW-1:0] s1_j,
   output logic          s1_last
);

   logic [IW-1:0] nx_i;
   logic [IW-1:0] nx_k;
   logic [IW-1:0] nx_j;

   lu_idx_step #(.K(K), .NMAX(NMAX)) u_step (
      .n       (n_q),
      .cur_i   (s1_i),
      .cur_k   (s1_k),
      .cur_j   (s1_j),
      .nxt_i   (nx_i),
      .nxt_k   (nx_k),
      .nxt_j   (nx_j),
      .is_last (s1_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_q      <= '0;
         s1_valid <= 1'b0;
         s1_i     <= '0;
         s1_k     <= '0;
         s1_j     <= '0;
      end else if (launch) begin
         n_q      <= n_in;
         s1_valid <= 1'b1;
         s1_i     <= IW'(1);
         s1_k     <= '0;
         s1_j     <= IW'(1);
      end else if (advance && s1_valid) begin
         if (s1_last) begin
            s1_valid <= 1'b0;
         end else begin
            s1_i <= nx_i;
            s1_k <= nx_k;
            s1_j <= nx_j;
         end
      end
   end

endmodule

// File: rtl/lu_idx_outreg.sv
module lu_idx_outreg #(
   parameter int NMAX = 128,
   localparam int IW  = $clog2(NMAX) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   input  logic          in_valid,
   input  logic [IW-1:0] in_i,
   input  logic [IW-1:0] in_k,
   input  logic [IW-1:0] in_j,
   input  logic          in_last,
   input  logic          ready,
   output logic          out_valid,
   output logic [IW-1:0] out_i,
   output logic [IW-1:0] out_k,
   output logic [IW-1:0] out_j,
   output logic          out_done
);

   logic out_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_k     <= '0;
         out_j     <= '0;
         out_last  <= 1'b0;
         out_done  <= 1'b0;
      end else begin
         if (advance) begin
            out_valid <= in_valid;
            out_i     <= in_i;
            out_k     <= in_k;
            out_j     <= in_j;
            out_last  <= in_valid && in_last;
         end
         out_done <= out_valid && ready && out_last;
      end
   end

endmodule

// File: rtl/lu_idx_gen.sv
module lu_idx_gen
   import lu_idx_pkg::*;
#(
   parameter int K    = 8,
   parameter int NMAX = 128,
   localparam int IW  = $clog2(NMAX) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] n_order,
   input  logic          ready,
   output logic          idx_valid,
   output logic [IW-1:0] idx_i,
   output logic [IW-1:0] idx_k,
   output logic [IW-1:0] idx_j,
   output logic          done
);

   // R10: parameter legality
   generate
      if (!is_pow2(K) || !is_pow2(NMAX) || (K > NMAX)) begin : g_bad_param
         $error("lu_idx_gen: K and NMAX must be powers of two with K <= NMAX");
      end
   endgenerate

   logic          busy;
   logic          launch;
   logic          advance;
   logic [IW-1:0] n_q;
   logic          s1_valid;
   logic [IW-1:0] s1_i;
   logic [IW-1:0] s1_k;
   logic [IW-1:0] s1_j;
   logic          s1_last;

   assign busy    = s1_valid || idx_valid;
   assign launch  = start && !busy;           // R8: ignored while busy
   assign advance = ready || !idx_valid;      // R5: hold while stalled

   lu_idx_front #(.K(K), .NMAX(NMAX)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .advance  (advance),
      .n_in     (n_order),
      .n_q      (n_q),
      .s1_valid (s1_valid),
      .s1_i     (s1_i),
      .s1_k     (s1_k),
      .s1_j     (s1_j),
      .s1_last  (s1_last)
   );

   lu_idx_outreg #(.NMAX(NMAX)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .in_valid  (s1_valid),
      .in_i      (s1_i),
      .in_k      (s1_k),
      .in_j      (s1_j),
      .in_last   (s1_last),
      .ready     (ready),
      .out_valid (idx_valid),
      .out_i     (idx_i),
      .out_k     (idx_k),
      .out_j     (idx_j),
      .out_done  (done)
   );

endmodule

// File: rtl/lu_idx_chk.sv
module lu_idx_chk #(
   parameter int K    = 8,
   parameter int NMAX = 128,
   localparam int IW  = $clog2(NMAX) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ready,
   input logic          idx_valid,
   input logic [IW-1:0] idx_i,
   input logic [IW-1:0] idx_k,
   input logic [IW-1:0] idx_j,
   input logic          done,
   input logic [IW-1:0] n_q
);

   a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid && !ready |=> idx_valid && $stable(idx_i) && $stable(idx_k) && $stable(idx_j));

   a_r3_j_window: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> (idx_j >= idx_i) && (idx_j <= n_q) && (idx_i >= IW'(1)));

   a_r4_k_window: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> ((int'(idx_k) % K) == 0)
                    && (int'(idx_k) >= ((int'(idx_i) - 1) / K) * K)
                    && (int'(idx_k) + K <= int'(n_q) + 1));

   a_r6_j_increment: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid && ready && (idx_j != n_q) |=>
         idx_valid && (idx_j == $past(idx_j) + IW'(1)) && $stable(idx_i) && $stable(idx_k));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(idx_valid && ready) && !idx_valid);

endmodule

bind lu_idx_gen lu_idx_chk #(.K(K), .NMAX(NMAX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ready     (ready),
   .idx_valid (idx_valid),
   .idx_i     (idx_i),
   .idx_k     (idx_k),
   .idx_j     (idx_j),
   .done      (done),
   .n_q       (n_q)
);

// File: tb/lu_idx_gen_tb.sv
module lu_idx_gen_tb;

   localparam int K       = 4;
   localparam int NMAX    = 32;
   localparam int IW      = $clog2(NMAX) + 1;
   localparam int CLK_PER = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [IW-1:0] n_order = '0;
   logic          ready = 1'b1;
   logic          idx_valid;
   logic [IW-1:0] idx_i;
   logic [IW-1:0] idx_k;
   logic [IW-1:0] idx_j;
   logic          done;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";

   // behavioural model state
   int q[$];
   int phase = 0;
   bit exp_done = 0;
   int done_cnt = 0;
   int accept_cnt = 0;

   always #(CLK_PER / 2) clk = ~clk;

   lu_idx_gen #(.K(K), .NMAX(NMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .n_order(n_order), .ready(ready),
      .idx_valid(idx_valid), .idx_i(idx_i), .idx_k(idx_k), .idx_j(idx_j), .done(done)
   );

   function automatic int pack3(int i, int k, int j);
      return (i << 16) | (k << 8) | j;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int seq_len(int n);
      int cnt = 0;
      for (int i = 1; i <= n; i++)
         for (int k = ((i - 1) / K) * K; k <= n + 1 - K; k += K)
            cnt += n - i + 1;
      return cnt;
   endfunction

   // model advance on each rising edge
   always @(posedge clk) begin
      exp_done = 0;
      if (!rst_n) begin
         phase = 0;
         q.delete();
      end else begin
         if (idx_valid && ready) accept_cnt++;
         if (done) done_cnt++;
         case (phase)
            0: if (start) begin
               for (int i = 1; i <= int'(n_order); i++)
                  for (int k = ((i - 1) / K) * K; k <= int'(n_order) + 1 - K; k += K)
                     for (int j = i; j <= int'(n_order); j++)
                        q.push_back(pack3(i, k, j));
               phase = 1;
            end
            1: phase = 2;
            default: if (ready) begin
               void'(q.pop_front());
               if (q.size() == 0) begin
                  phase = 0;
                  exp_done = 1;
               end
            end
         endcase
      end
   end

   // clock-by-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(idx_valid == (phase == 2), {cur_tag, " valid"}, idx_valid, phase == 2);
         if (phase == 2 && idx_valid)
            check(pack3(idx_i, idx_k, idx_j) == q[0], {cur_tag, " triple"},
                  pack3(idx_i, idx_k, idx_j), q[0]);
         check(done == exp_done, "R7 done", done, exp_done);
      end
   end

   task automatic run_job(int n, int mode);
      int cyc = 0;
      int d0;
      int a0;
      int lfsr = 16'hACE1;
      d0 = done_cnt;
      a0 = accept_cnt;
      @(negedge clk);
      n_order = IW'(n);
      start = 1'b1;
      ready = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: nothing presented one clock after start sampled
      check(idx_valid == 1'b0, "R2 first gap", idx_valid, 0);
      @(negedge clk);
      check(idx_valid && pack3(idx_i, idx_k, idx_j) == pack3(1, 0, 1), "R2 first triple",
            pack3(idx_i, idx_k, idx_j), pack3(1, 0, 1));
      while (done_cnt == d0 && !done && cyc < 40000) begin
         case (mode)
            0: ready = 1'b1;
            1: ready = (cyc % 3) != 0;
            default: begin
               lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
               ready = lfsr[0] | lfsr[3];
            end
         endcase
         if (mode == 2 && (cyc == 7 || cyc == 50)) begin
            start = 1'b1;                      // R8: ignored while busy
            n_order = IW'(8);                  // R9: no effect mid-run
         end else begin
            start = 1'b0;
            n_order = IW'(n);
         end
         if (mode == 1 && !ready && idx_valid) begin
            int held = pack3(idx_i, idx_k, idx_j);
            @(negedge clk);
            check(idx_valid && pack3(idx_i, idx_k, idx_j) == held, "R5 stall hold",
                  pack3(idx_i, idx_k, idx_j), held);
            cyc++;
            continue;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      ready = 1'b1;
      repeat (3) @(negedge clk);
      check(done_cnt - d0 == 1, "R7 one done pulse", done_cnt - d0, 1);
      check(accept_cnt - a0 == seq_len(n), {cur_tag, " accepted count"}, accept_cnt - a0, seq_len(n));
      check(idx_valid == 1'b0, "R8 idle after run", idx_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(idx_valid == 1'b0 && done == 1'b0, "R1 in reset", {idx_valid, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(idx_valid == 1'b0 && done == 1'b0, "R1 after reset", {idx_valid, done}, 0);
      cur_tag = "R3";
      run_job(4, 0);
      cur_tag = "R5";
      run_job(8, 1);
      cur_tag = "R9";
      run_job(16, 2);
      cur_tag = "R4";
      run_job(32, 0);
      cur_tag = "R6";
      run_job(16, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule